// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a bus-attached timer. It has a 32-bit up-counter that advances on prescaled ticks of a selectable count source, and one compare channel. Software reads the counter as a running time base. To schedule a single future event, software writes a target value into the compare register. When the counter steps onto that value, a sticky match flag is raised. If the flag is unmasked, it drives a level interrupt until software clears it.

The register port has an address, write data, separate write and read strobes, and a combinational read-data return that is valid while the read strobe is high. The count source is one of two: every clock cycle, or only the cycles in which the `ref_tick` enable input is high. A `cpu_wait` input reports that the processor is idle. The timer either pauses during that state or keeps running, depending on a control bit. In the default free-running mode the counter rolls over modulo 2^32. In restart mode the counter returns to zero after reaching the compare value, which gives a repeating period.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Control bit 0 is the run enable. While it is 0 the counter holds its value. A control write whose data is all zero also forces the counter and the prescaler phase to 0.
- R3: With prescaler value P (register at offset 0x04, 12 bits), the counter advances by one on every (P+1)-th qualifying source tick.
- R4: Control bit 6 = 1 makes every clock cycle a source tick. Control bit 6 = 0 makes only the cycles with `ref_tick` high count.
- R5: While `cpu_wait` is high, source ticks are suppressed if control bit 3 is 0. If control bit 3 is 1, they count as usual.
- R6: With control bit 9 = 1 (free-run), the counter keeps incrementing past a match.
- R7: With control bit 9 = 0 (restart), the step that follows the counter equalling the compare register (offset 0x10) loads 0 instead of incrementing.
- R8: Status bit 0 (offset 0x08) is set when a counter step produces a value equal to the compare register. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R9: When a flag set and a write-one-clear happen on the same clock edge, the flag ends up set.
- R10: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 (offset 0x0c) are both 1.
- R11: Reads return only defined bits, with all other bits 0. Control returns bits 0, 3, 6 and 9, the prescaler returns 12 bits, status and interrupt-enable return bit 0, compare returns 32 bits, and the counter is read at offset 0x24.
- R12: Reads of any other offset return 0, and writes to them change nothing. Writes to the counter offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, 0 otherwise |
| ref_tick | input | 1 | Alternate count source enable |
| cpu_wait | input | 1 | Processor wait-state indication |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties are checked on every cycle. They cover the following: the counter stays still when no step occurs, a step adds exactly one or (in restart mode at the compare value) lands on zero, a free-run step onto the compare value leaves the flag set, a clear without a step drops the flag, steps are spaced by the prescaler, and no step happens while the enable bit is off. Some behaviours can only be shown by the directed scenarios, because each depends on a full sequence of register accesses and source activity: the exact step counts seen through the bus, the `ref_tick` and wait gating, the flag winning over a clear on the same edge, the interrupt masking, and the read-back masks and undefined offsets.

// File: rtl/cmp_timer_pkg.sv
// cmp_timer_pkg: register offsets and control bit positions shared by the
// timer modules. Assumes byte offsets on an 8-bit or wider address.
package cmp_timer_pkg;
    localparam int unsigned OFS_CTRL  = 32'h00;
    localparam int unsigned OFS_PSC   = 32'h04;
    localparam int unsigned OFS_STAT  = 32'h08;
    localparam int unsigned OFS_IEN   = 32'h0c;
    localparam int unsigned OFS_CMP   = 32'h10;
    localparam int unsigned OFS_COUNT = 32'h24;

    localparam int unsigned CB_RUN   = 0;
    localparam int unsigned CB_WAIT  = 3;
    localparam int unsigned CB_CLKPE = 6;
    localparam int unsigned CB_FREE  = 9;

    typedef struct packed {
        logic free_run;
        logic clk_periph;
        logic wait_run;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/cmp_timer_regs.sv
// cmp_timer_regs: register storage, write decode and read multiplexer.
// Assumes single-cycle write strobes; read data is combinational and zero
// whenever the read strobe is low or the offset is not decoded.
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 32,
    parameter int PSC_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic              flag,
    input  logic [DW-1:0]     count,
    output ctrl_t             ctrl,
    output logic [PSC_W-1:0]  psc,
    output logic [DW-1:0]     cmp,
    output logic              ien,
    output logic              zero_wr,
    output logic              flag_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PSC   = ADDR_W'(OFS_PSC);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(OFS_CMP);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

    logic wr_ctrl, wr_psc, wr_stat, wr_ien, wr_cmp;

    // Decode write strobes per register.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_psc  = bus_wr && (bus_addr == A_PSC);
        wr_stat = bus_wr && (bus_addr == A_STAT);
        wr_ien  = bus_wr && (bus_addr == A_IEN);
        wr_cmp  = bus_wr && (bus_addr == A_CMP);
    end

    // Side-effect pulses toward the counter core.
    assign zero_wr  = wr_ctrl && (bus_wdata == '0);
    assign flag_clr = wr_stat && bus_wdata[0];

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.run        <= bus_wdata[CB_RUN];
            ctrl.wait_run   <= bus_wdata[CB_WAIT];
            ctrl.clk_periph <= bus_wdata[CB_CLKPE];
            ctrl.free_run   <= bus_wdata[CB_FREE];
        end
    end

    // Prescaler, compare and interrupt-enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc <= '0;
            cmp <= '0;
            ien <= 1'b0;
        end else begin
            if (wr_psc) psc <= bus_wdata[PSC_W-1:0];
            if (wr_cmp) cmp <= bus_wdata;
            if (wr_ien) ien <= bus_wdata[0];
        end
    end

    // Read multiplexer returning defined bits only.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_CTRL) begin
                bus_rdata[CB_RUN]   = ctrl.run;
                bus_rdata[CB_WAIT]  = ctrl.wait_run;
                bus_rdata[CB_CLKPE] = ctrl.clk_periph;
                bus_rdata[CB_FREE]  = ctrl.free_run;
            end else if (bus_addr == A_PSC) begin
                bus_rdata[PSC_W-1:0] = psc;
            end else if (bus_addr == A_STAT) begin
                bus_rdata[0] = flag;
            end else if (bus_addr == A_IEN) begin
                bus_rdata[0] = ien;
            end else if (bus_addr == A_CMP) begin
                bus_rdata = cmp;
            end else if (bus_addr == A_COUNT) begin
                bus_rdata = count;
            end
        end
    end
endmodule

// File: rtl/cmp_timer_prescale.sv
// cmp_timer_prescale: qualifies source ticks (source select, run enable,
// wait gating) and divides them by psc+1 into counter steps.
// Assumes ref_tick is synchronous to clk. A prescaler lowered below the
// current phase ends the period at once instead of rolling the phase over.
module cmp_timer_prescale #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clk_periph,
    input  logic             wait_run,
    input  logic             ref_tick,
    input  logic             cpu_wait,
    input  logic             sync_clr,
    input  logic [PSC_W-1:0] psc,
    output logic             step
);
    logic [PSC_W-1:0] phase;
    logic             tick;
    logic             last;

    // Source tick qualification.
    always_comb begin
        tick = run && (clk_periph || ref_tick) && (!cpu_wait || wait_run);
        last = (phase >= psc);
        step = tick && last;
    end

    // Prescaler phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_clr) begin
            phase <= '0;
        end else if (tick) begin
            phase <= last ? '0 : phase + PSC_W'(1);
        end
    end

    // Steps are separated by at least psc+1 ticks.
    p_step_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sync_clr && psc != '0) |=> (!step || psc == '0))
        else $error("prescaled steps too close");
endmodule

// File: rtl/cmp_timer_core.sv
// cmp_timer_core: the 32-bit counter and the compare-match flag.
// Assumes step is already prescaled; sync_clr has priority over a step.
module cmp_timer_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          free_run,
    input  logic [DW-1:0] cmp,
    input  logic          sync_clr,
    input  logic          flag_clr,
    output logic [DW-1:0] count,
    output logic          flag
);
    logic [DW-1:0] count_nxt;
    logic          hit;

    // Next counter value and match detection.
    always_comb begin
        count_nxt = (!free_run && count == cmp) ? '0 : count + DW'(1);
        hit       = step && (count_nxt == cmp);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_clr) begin
            count <= '0;
        end else if (step) begin
            count <= count_nxt;
        end
    end

    // Sticky match flag; a set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !sync_clr) |=> $stable(count))
        else $error("counter moved without a step");

    p_increment_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sync_clr && (free_run || count != cmp)) |=> (count == $past(count) + DW'(1)))
        else $error("counter did not add one");

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sync_clr && !free_run && count == cmp) |=> (count == '0))
        else $error("restart mode did not reload zero");

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && free_run && (count + DW'(1)) == cmp) |=> flag)
        else $error("match did not set flag");

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !step) |=> !flag)
        else $error("write-one did not clear flag");
endmodule

// File: rtl/cmp_timer.sv
// cmp_timer: bus-attached compare-match timer top level. Ties the register
// file, the tick prescaler and the counter core together and forms the
// level interrupt. Assumes a single clock domain for bus and count logic.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 32,
    parameter int PSC_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ref_tick,
    input  logic              cpu_wait,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [PSC_W-1:0] psc;
    logic [DW-1:0]    cmp;
    logic [DW-1:0]    count;
    logic             ien;
    logic             flag;
    logic             zero_wr;
    logic             flag_clr;
    logic             step;

    cmp_timer_regs #(.ADDR_W(ADDR_W), .DW(DW), .PSC_W(PSC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .flag      (flag),
        .count     (count),
        .ctrl      (ctrl),
        .psc       (psc),
        .cmp       (cmp),
        .ien       (ien),
        .zero_wr   (zero_wr),
        .flag_clr  (flag_clr)
    );

    cmp_timer_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run),
        .clk_periph (ctrl.clk_periph),
        .wait_run   (ctrl.wait_run),
        .ref_tick   (ref_tick),
        .cpu_wait   (cpu_wait),
        .sync_clr   (zero_wr),
        .psc        (psc),
        .step       (step)
    );

    cmp_timer_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .free_run (ctrl.free_run),
        .cmp      (cmp),
        .sync_clr (zero_wr),
        .flag_clr (flag_clr),
        .count    (count),
        .flag     (flag)
    );

    // Level interrupt: flag masked by the enable bit.
    assign irq = flag && ien;

    p_no_step_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !step)
        else $error("step while run enable is off");
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A_CTRL = 8'h00, A_PSC = 8'h04, A_STAT = 8'h08,
                           A_IEN = 8'h0c, A_CMP = 8'h10, A_CNT = 8'h24;
    localparam logic [31:0] BIG = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        cpu_wait = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .cpu_wait(cpu_wait), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a negedge; one write edge, returns at the next negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational read between edges.
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stop, configure, clear flag, then start; returns with counter at 0.
    task automatic start(input logic [31:0] c, input logic [31:0] p, input logic [31:0] k);
        wr(A_CTRL, 32'h0);
        wr(A_PSC, p);
        wr(A_CMP, k);
        wr(A_STAT, 32'h1);
        wr(A_CTRL, c);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", A_CTRL, 0);
        expect_reg("R1 psc", A_PSC, 0);
        expect_reg("R1 stat", A_STAT, 0);
        expect_reg("R1 ien", A_IEN, 0);
        expect_reg("R1 cmp", A_CMP, 0);
        expect_reg("R1 count", A_CNT, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_enable_hold();
        start(32'h241, 0, BIG);
        waitn(10);
        expect_reg("R2 running", A_CNT, 10);
        wr(A_CTRL, 32'h240);
        expect_reg("R2 stop edge", A_CNT, 11);
        waitn(5);
        expect_reg("R2 held", A_CNT, 11);
        wr(A_CTRL, 32'h0);
        expect_reg("R2 zero write", A_CNT, 0);
    endtask

    task automatic t_prescale();
        start(32'h241, 3, BIG);
        waitn(12);
        expect_reg("R3 div4 12 ticks", A_CNT, 3);
        waitn(1);
        expect_reg("R3 div4 13 ticks", A_CNT, 3);
        waitn(3);
        expect_reg("R3 div4 16 ticks", A_CNT, 4);
    endtask

    task automatic t_source();
        ref_tick = 1'b0;
        start(32'h201, 0, BIG);
        waitn(5);
        expect_reg("R4 no ref ticks", A_CNT, 0);
        ref_tick = 1'b1;
        waitn(3);
        ref_tick = 1'b0;
        expect_reg("R4 three ref ticks", A_CNT, 3);
        waitn(4);
        expect_reg("R4 idle again", A_CNT, 3);
    endtask

    task automatic t_wait();
        start(32'h241, 0, BIG);
        cpu_wait = 1'b1;
        waitn(4);
        expect_reg("R5 paused in wait", A_CNT, 0);
        wr(A_CTRL, 32'h249);
        expect_reg("R5 enable edge", A_CNT, 0);
        waitn(4);
        expect_reg("R5 runs in wait", A_CNT, 4);
        cpu_wait = 1'b0;
    endtask

    task automatic t_freerun();
        start(32'h241, 0, 5);
        waitn(5);
        expect_reg("R6 at compare", A_CNT, 5);
        expect_reg("R8 flag on match", A_STAT, 1);
        waitn(3);
        expect_reg("R6 past compare", A_CNT, 8);
    endtask

    task automatic t_restart();
        start(32'h041, 0, 5);
        waitn(5);
        expect_reg("R7 at compare", A_CNT, 5);
        waitn(1);
        expect_reg("R7 reload zero", A_CNT, 0);
        waitn(6);
        expect_reg("R7 second reload", A_CNT, 0);
        waitn(2);
        expect_reg("R7 after reload", A_CNT, 2);
        expect_reg("R8 flag restart", A_STAT, 1);
    endtask

    task automatic t_flag_clear();
        start(32'h241, 0, 3);
        waitn(3);
        expect_reg("R8 flag set", A_STAT, 1);
        wr(A_STAT, 32'hFFFF_FFFE);
        expect_reg("R8 write zero keeps", A_STAT, 1);
        wr(A_STAT, 32'h1);
        expect_reg("R8 write one clears", A_STAT, 0);
    endtask

    task automatic t_set_wins();
        start(32'h241, 0, 3);
        waitn(2);
        wr(A_STAT, 32'h1);
        expect_reg("R9 set beats clear", A_STAT, 1);
        wr(A_STAT, 32'h1);
        expect_reg("R9 later clear", A_STAT, 0);
    endtask

    task automatic t_irq();
        wr(A_IEN, 0);
        start(32'h241, 0, 3);
        waitn(3);
        check("R10 masked", {31'b0, irq}, 0);
        wr(A_IEN, 1);
        check("R10 unmasked", {31'b0, irq}, 1);
        wr(A_IEN, 0);
        check("R10 remasked", {31'b0, irq}, 0);
        wr(A_IEN, 1);
        wr(A_STAT, 1);
        check("R10 flag cleared", {31'b0, irq}, 0);
    endtask

    task automatic t_regmap();
        wr(A_CTRL, 32'hFFFF_FFFE);
        expect_reg("R11 ctrl bits", A_CTRL, 32'h248);
        wr(A_CTRL, 32'h0);
        wr(A_PSC, 32'hFFFF_FFFF);
        expect_reg("R11 psc width", A_PSC, 32'hFFF);
        wr(A_IEN, 32'hFFFF_FFFF);
        expect_reg("R11 ien width", A_IEN, 1);
        wr(A_CMP, 32'hDEAD_BEEF);
        expect_reg("R11 cmp", A_CMP, 32'hDEAD_BEEF);
    endtask

    task automatic t_undef();
        wr(A_CTRL, 0);
        wr(A_IEN, 0);
        wr(A_PSC, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h2c, 32'hFFFF_FFFF);
        expect_reg("R12 ctrl untouched", A_CTRL, 0);
        expect_reg("R12 ien untouched", A_IEN, 0);
        expect_reg("R12 psc untouched", A_PSC, 0);
        expect_reg("R12 read 0x14", 8'h14, 0);
        expect_reg("R12 read 0x2c", 8'h2c, 0);
        wr(A_CNT, 32'h1234);
        expect_reg("R12 count write ignored", A_CNT, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_hold();
        t_prescale();
        t_source();
        t_wait();
        t_freerun();
        t_restart();
        t_flag_clear();
        t_set_wins();
        t_irq();
        t_regmap();
        t_undef();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule